// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation converter. A start request puts it into a conversion. It drives a trial code to an external DAC and comparator and reads back a one-bit decision. It walks the code from the most significant bit downward, one bit per fixed number of clocks, and finally writes the code into an output register. A busy flag covers the whole conversion. A track/hold control tells the analog sampler when to follow the input and when to freeze it. A one-cycle done strobe marks the moment the busy flag drops.

Two options are captured with each start request. The short-cycle option stops the search after the upper bits, and the unresolved low bits of the result read as zero. The emulation option makes the sampler keep tracking for a programmable acquisition window after the start request, before it holds and begins the first trial. In the default control mode the hold and the first trial begin right away. Start requests that arrive during a conversion are dropped, so a conversion can be neither restarted nor cut short.

Top module: `sarSequencer`

## Requirements
- R1: Each bit period presents a trial code in which the bits above the bit under test hold their decided values, the bit under test is 1 and every lower bit is 0. The first trial is the MSB alone (0x800 for 12 bits). A comparator value of 1 keeps the bit and 0 clears it.
- R2: `shortCycle` is captured on the accepted start. A value of 0 resolves all RES_BITS bits; a value of 1 resolves only SHORT_BITS bits (12 and 8 by default). Changing it after the start has no effect on that conversion.
- R3: After a short-cycle conversion the low RES_BITS-SHORT_BITS result bits are 0.
- R4: A start request seen at a clock edge while idle makes `busy` high from that edge for exactly A + CLKS_PER_BIT*N + 1 cycles. N is the number of resolved bits. A is ACQ_CYCLES in emulation mode and 0 in control mode.
- R5: A start request seen while `busy` is high has no effect on the outputs, including one seen in the last busy cycle.
- R6: `trackEn` rises at the edge where the last bit is decided, one cycle before `busy` falls. It stays high until the next accepted start (control mode) or the end of the acquisition window (emulation mode).
- R7: `emuMode` is captured on the accepted start. A value of 0 drops `trackEn` at the start edge. A value of 1 keeps `trackEn` high for ACQ_CYCLES cycles and then drops it when the first trial begins.
- R8: The comparator input is sampled on the last clock of each bit period. The result register is loaded at the edge of the final decision and holds its value while idle.
- R9: With synchronous active-high reset, the block is idle: `busy`=0, `trackEn`=1, `donePulse`=0 and `dataOut`=0.
- R10: `donePulse` is high for exactly one cycle, the first cycle with `busy` low after a conversion. A start request in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Convert request, sampled each edge |
| shortCycle | input | 1 | 1 = short search, captured at start |
| emuMode | input | 1 | 1 = acquisition delay before hold, captured at start |
| compIn | input | 1 | Comparator decision, 1 = input at or above trial |
| trialCode | output | RES_BITS | Code driven to the DAC |
| trackEn | output | 1 | 1 = sampler tracks, 0 = hold |
| busy | output | 1 | Conversion in progress |
| dataOut | output | RES_BITS | Result register |
| donePulse | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The final bit decision and the end of the busy flag meet a new start request at the close of every conversion. The bench provokes both cases. It raises a start request in the last busy cycle, where the request must be dropped. It also raises one in the done cycle, where the request must be accepted back to back. A behavioural model judges each cycle on busy, track, done, result and trial code. The same runs change `shortCycle` in mid-conversion to show that the value captured at the start governs the length.

// File: rtl/sarSeqPkg.sv
package sarSeqPkg;
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV, ST_WRAP} seqState_t;

  typedef struct packed {
    logic             loadFirst;
    logic             decide;
    logic             lastBit;
    logic [IDX_W-1:0] bitIdx;
  } seqStrobes_t;
endpackage

// File: rtl/sarSeqCtrl.sv
module sarSeqCtrl
  import sarSeqPkg::*;
#(
  parameter int RES_BITS     = 12,
  parameter int SHORT_BITS   = 8,
  parameter int CLKS_PER_BIT = 4,
  parameter int ACQ_CYCLES   = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        shortCycle,
  input  logic        emuMode,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        trackEn,
  output logic        donePulse
);
  localparam int CNT_MAX = (CLKS_PER_BIT > ACQ_CYCLES) ? CLKS_PER_BIT : ACQ_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(RES_BITS - 1);
  localparam logic [IDX_W-1:0] SHORT_IDX = IDX_W'(RES_BITS - SHORT_BITS);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             shortLat;
  logic             doneQ;
  logic             trialEnd;
  logic             acqEnd;
  logic             lastBit;

  assign trialEnd = (state == ST_CONV) && (cnt == CNT_W'(CLKS_PER_BIT - 1));
  assign acqEnd   = (state == ST_ACQ) && (cnt == CNT_W'(ACQ_CYCLES - 1));
  assign lastBit  = bitIdx == (shortLat ? SHORT_IDX : '0);

  always_comb begin
    strobes.loadFirst = ((state == ST_IDLE) && startReq && !emuMode) || acqEnd;
    strobes.decide    = trialEnd;
    strobes.lastBit   = lastBit;
    strobes.bitIdx    = bitIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      shortLat <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          doneQ <= 1'b0;
          if (startReq) begin
            shortLat <= shortCycle;
            cnt      <= '0;
            bitIdx   <= TOP_IDX;
            state    <= emuMode ? ST_ACQ : ST_CONV;
          end
        end
        ST_ACQ: begin
          if (acqEnd) begin
            cnt   <= '0;
            state <= ST_CONV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (trialEnd) begin
            cnt <= '0;
            if (lastBit) state <= ST_WRAP;
            else         bitIdx <= bitIdx - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
      endcase
    end
  end

  assign busy      = state != ST_IDLE;
  assign trackEn   = (state != ST_CONV);
  assign donePulse = doneQ;
endmodule

// File: rtl/sarSeqData.sv
module sarSeqData
  import sarSeqPkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobes_t         strobes,
  input  logic                compIn,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] dataOut
);
  localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

  logic [RES_BITS-1:0] trialReg;
  logic [RES_BITS-1:0] resultReg;
  logic [RES_BITS-1:0] testMask;
  logic [RES_BITS-1:0] lowerMask;
  logic [RES_BITS-1:0] decided;

  always_comb begin
    testMask  = ONE << strobes.bitIdx;
    lowerMask = (strobes.bitIdx == '0) ? '0 : (ONE << (strobes.bitIdx - 1'b1));
    decided   = compIn ? trialReg : (trialReg & ~testMask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trialReg  <= '0;
      resultReg <= '0;
    end else if (strobes.loadFirst) begin
      trialReg <= ONE << (RES_BITS - 1);
    end else if (strobes.decide) begin
      if (strobes.lastBit) begin
        trialReg  <= decided;
        resultReg <= decided;
      end else begin
        trialReg <= decided | lowerMask;
      end
    end
  end

  assign trialCode = trialReg;
  assign dataOut   = resultReg;
endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sarSeqPkg::*;
#(
  parameter int RES_BITS     = 12,
  parameter int SHORT_BITS   = 8,
  parameter int CLKS_PER_BIT = 4,
  parameter int ACQ_CYCLES   = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic                shortCycle,
  input  logic                emuMode,
  input  logic                compIn,
  output logic [RES_BITS-1:0] trialCode,
  output logic                trackEn,
  output logic                busy,
  output logic [RES_BITS-1:0] dataOut,
  output logic                donePulse
);
  seqStrobes_t strobes;

  sarSeqCtrl #(
    .RES_BITS(RES_BITS), .SHORT_BITS(SHORT_BITS),
    .CLKS_PER_BIT(CLKS_PER_BIT), .ACQ_CYCLES(ACQ_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .shortCycle(shortCycle),
    .emuMode(emuMode), .strobes(strobes), .busy(busy), .trackEn(trackEn),
    .donePulse(donePulse)
  );

  sarSeqData #(.RES_BITS(RES_BITS)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .compIn(compIn),
    .trialCode(trialCode), .dataOut(dataOut)
  );
endmodule

// File: rtl/sarSeqChecker.sv
module sarSeqChecker #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                startReq,
  input logic                trackEn,
  input logic                busy,
  input logic [RES_BITS-1:0] dataOut,
  input logic                donePulse
);
  // R4: busy only rises after a start request seen at that edge
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startReq));

  // R10: done strobe coincides with the busy fall
  p_done_fall_r10: assert property (@(posedge clk) disable iff (rst)
    donePulse |-> $fell(busy));

  // R10: done strobe lasts one cycle
  p_done_one_r10: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse);

  // R6: sampler already tracks in the last busy cycle
  p_track_before_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(trackEn));

  // R8: result register holds while idle
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst)) |-> $stable(dataOut));

  // R9: idle implies tracking
  p_idle_track_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> trackEn);
endmodule

bind sarSequencer sarSeqChecker #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst(rst), .startReq(startReq), .trackEn(trackEn),
  .busy(busy), .dataOut(dataOut), .donePulse(donePulse)
);

// File: tb/sarSequencer_tb.sv
module sarSequencer_tb;
  localparam int RB   = 12;
  localparam int SB   = 8;
  localparam int CLKS = 4;
  localparam int ACQ  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic shortCycle = 1'b0;
  logic emuMode = 1'b0;
  logic compIn;
  logic [RB-1:0] trialCode;
  logic trackEn, busy, donePulse;
  logic [RB-1:0] dataOut;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 1'b0;

  // model state
  int k = -1;
  int acqN = 0;
  int nBits = RB;
  int tot = 0;
  int target = 0;
  int expRes = 0;
  int convVin = 0;
  bit expDone = 1'b0;

  always #10 clk = ~clk;

  // ideal comparator
  assign compIn = (int'(trialCode) <= vin);

  sarSequencer #(.RES_BITS(RB), .SHORT_BITS(SB), .CLKS_PER_BIT(CLKS), .ACQ_CYCLES(ACQ)) u_dut (
    .clk(clk), .rst(rst), .startReq(startReq), .shortCycle(shortCycle), .emuMode(emuMode),
    .compIn(compIn), .trialCode(trialCode), .trackEn(trackEn), .busy(busy),
    .dataOut(dataOut), .donePulse(donePulse)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %0h expected %0h", tag, cycles, got, exp);
    end
  endtask

  // behavioural reference, advanced on each edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      k = -1; expRes = 0; expDone = 0;
    end else if (k < 0) begin
      expDone = 0;
      if (startReq) begin
        k = 0;
        acqN = emuMode ? ACQ : 0;
        nBits = shortCycle ? SB : RB;
        tot = acqN + CLKS * nBits + 1;
        convVin = vin;
        target = (vin >> (RB - nBits)) << (RB - nBits);
      end
    end else begin
      k++;
      if (k == acqN + CLKS * nBits) expRes = target;
      if (k == tot) begin
        k = -1;
        expDone = 1;
      end
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (running) begin
      bit hold;
      hold = (k >= acqN) && (k < acqN + CLKS * nBits);
      check(rst ? "R9 busy" : "R4/R5 busy", busy, (k >= 0));
      check(rst ? "R9 track" : "R6/R7 track", trackEn, !hold);
      check(rst ? "R9 done" : "R10 done", donePulse, expDone);
      check(rst ? "R9 data" : "R8 data", dataOut, expRes);
      if (hold) begin
        int j;
        int upper;
        j = (k - acqN) / CLKS;
        upper = convVin & ~((1 << (RB - j)) - 1);
        check("R1 trial", trialCode, upper | (1 << (RB - 1 - j)));
      end
    end
  end

  // caller is at a negedge; pokeAt counts busy cycles after the start
  task automatic runConv(input int v, input bit s, input bit e, input int pokeAt);
    int n;
    n = 0;
    vin = v; shortCycle = s; emuMode = e; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (busy) begin
      n++;
      if (n == pokeAt) begin
        startReq = 1'b1;
        shortCycle = !s;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    check(s ? "R3 short result" : "R2 full result", dataOut,
          s ? ((v >> (RB - SB)) << (RB - SB)) : v);
    check("R10 done at fall", donePulse, 1);
  endtask

  initial begin
    running = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset data", dataOut, 0);
    check("R9 reset track", trackEn, 1);
    // control mode, full length
    runConv(12'hA5C, 0, 0, -1);
    @(negedge clk);
    runConv(0, 0, 0, -1);
    @(negedge clk);
    runConv(12'hFFF, 0, 0, -1);
    @(negedge clk);
    runConv(12'h800, 0, 0, -1);
    @(negedge clk);
    runConv(12'h7FF, 0, 0, -1);
    // R10: back-to-back start in done cycle, short cycle
    runConv(12'hABC, 1, 0, -1);
    // R5: start poked mid-conversion with shortCycle flipped (R2)
    @(negedge clk);
    runConv(12'h3C7, 0, 0, 7);
    // R5: start in the last busy cycle is dropped
    @(negedge clk);
    runConv(12'h5A1, 0, 0, CLKS * RB + 1);
    repeat (2) @(negedge clk);
    runConv(12'h123, 1, 0, CLKS * SB + 1);
    // R7: emulation mode with acquisition window
    repeat (2) @(negedge clk);
    runConv(12'hC3E, 0, 1, -1);
    runConv(12'h9F7, 1, 1, 3);
    @(negedge clk);
    runConv(12'h001, 0, 1, ACQ + CLKS * RB + 1);
    // R8: hold between conversions
    repeat (5) @(negedge clk);
    check("R8 idle hold", dataOut, 12'h001);
    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog cycle %0d got hung expected completion", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule